// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This sequencer moves a group of registers between a 16-entry register file and word-addressed memory. A caller presents a bit mask that selects registers, a base address, one of four addressing modes, a load/store direction, a base-update flag and a user-bank flag, together with a one-cycle `start` pulse. The block counts the selected registers to find the lowest address of the block. It then walks the mask from the lowest index upward and issues one word beat per selected register on a valid/ready memory port.

On loads, each returned word is written into the register file. On stores, the register-file read data is presented as the write data. After the last beat the block emits a one-cycle completion pulse. In that same cycle it can publish the updated base value. For a load whose mask includes the program-counter register (index 15), it also signals a branch and, when the user-bank flag is set, a status-register restore.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_valid`, `rf_we`, `done`, `base_we`, `branch` and `psr_restore` are all 0.
- R2: The first beat address depends on `addr_mode`, with n = the number of set mask bits: 0 gives base, 1 gives base+4, 2 gives base-4n+4, 3 gives base-4n.
- R3: Registers are moved lowest index first. Each accepted beat advances the address by 4.
- R4: Exactly one beat is accepted per set mask bit. While `mem_valid` is high and `mem_ready` is low, the address and register index stay unchanged.
- R5: On a load (`is_load`=1), each accepted beat writes `mem_rdata` into the register at `rf_idx`. On a store, `mem_wdata` carries `rf_rd_data` and `mem_write` is 1.
- R6: `done` is high for exactly one cycle, in the cycle after the last accepted beat, and `busy` stays high from the cycle after `start` until that cycle.
- R7: An all-zero mask raises `done` in the cycle after `start`, with no memory beat.
- R8: With `wb_en`=1, `base_we` pulses with `done`, and `base_value` is base+4n for modes 0 and 1, or base-4n for modes 2 and 3. With `wb_en`=0, `base_we` stays 0.
- R9: A load whose mask has bit 15 set pulses `branch` with `done`, with `branch_target` equal to the word loaded into register 15. No other transfer raises `branch`.
- R10: A load with `user_bank`=1 and mask bit 15 set pulses `psr_restore` with `done`. Its register accesses use the current bank (`rf_user`=0).
- R11: With `user_bank`=1 and mask bit 15 clear, every register access uses the user bank (`rf_user`=1).
- R12: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| reg_mask | input | 16 | Register select mask, bit i = register i |
| base_addr | input | 32 | Base address |
| addr_mode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| is_load | input | 1 | 1 = memory to registers, 0 = registers to memory |
| wb_en | input | 1 | Publish the updated base on completion |
| user_bank | input | 1 | User-bank / status-restore flag |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_write | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| rf_idx | output | 4 | Register index of the current beat |
| rf_user | output | 1 | Access the user bank |
| rf_rd_data | input | 32 | Register-file read data for `rf_idx` |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_data | output | 32 | Register-file write data |
| base_we | output | 1 | Base update strobe |
| base_value | output | 32 | Updated base |
| branch | output | 1 | Program-counter redirect strobe |
| branch_target | output | 32 | Loaded program-counter value |
| psr_restore | output | 1 | Restore status register from saved copy |

## Verification
A wrong start offset or popcount shows on the very first beat as a bad `mem_addr`. A corrupted remaining-mask register shows one accepted beat later, as a repeated, skipped or out-of-order `rf_idx` or as a wrong beat count at `done`. Errors in the latched flags stay hidden until completion, where they appear as a wrong `base_value`, a missing or spurious `branch`/`psr_restore`, or data landing in the wrong bank, and the bench checks each of these at the `done` cycle.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
   typedef enum logic [1:0] {
      MODE_UP_POST   = 2'd0,
      MODE_UP_PRE    = 2'd1,
      MODE_DOWN_POST = 2'd2,
      MODE_DOWN_PRE  = 2'd3
   } walk_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_MOVE = 2'd1,
      SQ_FIN  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/bxs_popcount.sv
module bxs_popcount #(
   parameter int W        = 16,
   parameter bit USE_LOOP = 1'b1,
   localparam int CW      = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] cnt
);
   if (W < 1) begin : g_bad_w
      $error("bxs_popcount: W must be positive");
   end

   if (USE_LOOP) begin : g_loop
      always_comb begin
         cnt = '0;
         for (int i = 0; i < W; i++) cnt = cnt + CW'(vec[i]);
      end
   end else begin : g_chain
      logic [CW-1:0] part [W+1];
      assign part[0] = '0;
      for (genvar i = 0; i < W; i++) begin : g_stage
         assign part[i+1] = part[i] + CW'(vec[i]);
      end
      assign cnt = part[W];
   end
endmodule

// File: rtl/bxs_lowest.sv
module bxs_lowest #(
   parameter int W   = 16,
   localparam int IW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] idx
);
   if (W < 2) begin : g_bad_w
      $error("bxs_lowest: W must be at least 2");
   end

   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/bxs_addr_gen.sv
module bxs_addr_gen
   import bxs_pkg::*;
#(
   parameter int AW         = 32,
   parameter int CW         = 5,
   parameter int WORD_BYTES = 4,
   localparam int WSH       = $clog2(WORD_BYTES)
) (
   input  logic [AW-1:0] base,
   input  walk_mode_e    mode,
   input  logic [CW-1:0] count,
   output logic [AW-1:0] first_addr,
   output logic [AW-1:0] next_base
);
   if ((1 << WSH) != WORD_BYTES) begin : g_bad_word
      $error("bxs_addr_gen: WORD_BYTES must be a power of two");
   end

   logic [AW-1:0] span;
   logic [AW-1:0] step;

   assign span = AW'(count) << WSH;
   assign step = AW'(WORD_BYTES);

   always_comb begin
      unique case (mode)
         MODE_UP_POST:   first_addr = base;
         MODE_UP_PRE:    first_addr = base + step;
         MODE_DOWN_POST: first_addr = base - span + step;
         default:        first_addr = base - span;
      endcase
      next_base = mode[1] ? (base - span) : (base + span);
   end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
   import bxs_pkg::*;
#(
   parameter int  NREG       = 16,
   parameter int  AW         = 32,
   parameter int  DW         = 32,
   parameter int  WORD_BYTES = 4,
   parameter bit  CNT_LOOP   = 1'b1,
   localparam int IW         = $clog2(NREG),
   localparam int CW         = $clog2(NREG + 1),
   localparam int PC_IDX     = NREG - 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [NREG-1:0] reg_mask,
   input  logic [AW-1:0] base_addr,
   input  logic [1:0]    addr_mode,
   input  logic          is_load,
   input  logic          wb_en,
   input  logic          user_bank,
   output logic          busy,
   output logic          done,
   output logic          mem_valid,
   input  logic          mem_ready,
   output logic          mem_write,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic [IW-1:0] rf_idx,
   output logic          rf_user,
   input  logic [DW-1:0] rf_rd_data,
   output logic          rf_we,
   output logic [DW-1:0] rf_wr_data,
   output logic          base_we,
   output logic [AW-1:0] base_value,
   output logic          branch,
   output logic [DW-1:0] branch_target,
   output logic          psr_restore
);
   if (NREG < 2 || (1 << IW) != NREG) begin : g_bad_nreg
      $error("blk_xfer_seq: NREG must be a power of two of at least 2");
   end
   if (AW < 8 || DW < 8) begin : g_bad_width
      $error("blk_xfer_seq: AW and DW must be at least 8");
   end

   seq_state_e    st_q;
   logic [NREG-1:0] rem_q;
   logic [AW-1:0] addr_q;
   logic [AW-1:0] fin_base_q;
   logic          ld_q, wb_q, usr_q, pc_q;
   logic [DW-1:0] tgt_q;

   logic [CW-1:0] sel_cnt;
   logic [AW-1:0] first_addr, next_base;
   logic [IW-1:0] cur_idx;
   logic [NREG-1:0] rem_nxt;
   logic          beat, last_beat, take;

   bxs_popcount #(.W(NREG), .USE_LOOP(CNT_LOOP)) u_cnt (
      .vec (reg_mask),
      .cnt (sel_cnt)
   );

   bxs_addr_gen #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_agen (
      .base       (base_addr),
      .mode       (walk_mode_e'(addr_mode)),
      .count      (sel_cnt),
      .first_addr (first_addr),
      .next_base  (next_base)
   );

   bxs_lowest #(.W(NREG)) u_pick (
      .vec (rem_q),
      .idx (cur_idx)
   );

   assign take      = (st_q == SQ_IDLE) && start;
   assign beat      = (st_q == SQ_MOVE) && mem_ready;
   assign rem_nxt   = rem_q & (rem_q - NREG'(1));
   assign last_beat = (rem_nxt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SQ_IDLE;
         rem_q      <= '0;
         addr_q     <= '0;
         fin_base_q <= '0;
         ld_q       <= 1'b0;
         wb_q       <= 1'b0;
         usr_q      <= 1'b0;
         pc_q       <= 1'b0;
         tgt_q      <= '0;
      end else begin
         unique case (st_q)
            SQ_IDLE: begin
               if (take) begin
                  rem_q      <= reg_mask;
                  addr_q     <= first_addr;
                  fin_base_q <= next_base;
                  ld_q       <= is_load;
                  wb_q       <= wb_en;
                  usr_q      <= user_bank;
                  pc_q       <= reg_mask[PC_IDX];
                  st_q       <= (reg_mask == '0) ? SQ_FIN : SQ_MOVE;
               end
            end
            SQ_MOVE: begin
               if (beat) begin
                  rem_q  <= rem_nxt;
                  addr_q <= addr_q + AW'(WORD_BYTES);
                  if (ld_q && cur_idx == IW'(PC_IDX)) tgt_q <= mem_rdata;
                  if (last_beat) st_q <= SQ_FIN;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy          = (st_q != SQ_IDLE);
   assign done          = (st_q == SQ_FIN);
   assign mem_valid     = (st_q == SQ_MOVE);
   assign mem_write     = mem_valid && !ld_q;
   assign mem_addr      = addr_q;
   assign mem_wdata     = rf_rd_data;
   assign rf_idx        = cur_idx;
   assign rf_user       = busy && usr_q && !pc_q;
   assign rf_we         = beat && ld_q;
   assign rf_wr_data    = mem_rdata;
   assign base_we       = done && wb_q;
   assign base_value    = fin_base_q;
   assign branch        = done && ld_q && pc_q;
   assign branch_target = tgt_q;
   assign psr_restore   = done && ld_q && usr_q && pc_q;

   // R4
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(rf_idx)));

   // R3
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready && !last_beat) |=>
         (mem_valid && mem_addr == $past(mem_addr) + AW'(WORD_BYTES) && rf_idx > $past(rf_idx)));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   rf_we_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (mem_valid && mem_ready && !mem_write));

   // R9
   branch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      branch |-> (done && !mem_valid));

   // R10
   psr_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psr_restore |-> (branch && !rf_user));

   // R12
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && start) |=> (!mem_valid || mem_write == $past(mem_write)));
endmodule

// File: tb/sim_blk_xfer_seq.sv
module sim_blk_xfer_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] reg_mask = '0;
   logic [31:0] base_addr = '0;
   logic [1:0]  addr_mode = '0;
   logic        is_load = 1'b0, wb_en = 1'b0, user_bank = 1'b0;
   logic        busy, done, mem_valid, mem_write, rf_user, rf_we;
   logic        base_we, branch, psr_restore;
   logic        mem_ready;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wr_data;
   logic [31:0] base_value, branch_target;
   logic [3:0]  rf_idx;

   always #2.5 clk = ~clk;

   blk_xfer_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .reg_mask(reg_mask),
      .base_addr(base_addr), .addr_mode(addr_mode), .is_load(is_load),
      .wb_en(wb_en), .user_bank(user_bank), .busy(busy), .done(done),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .rf_idx(rf_idx), .rf_user(rf_user), .rf_rd_data(rf_rd_data),
      .rf_we(rf_we), .rf_wr_data(rf_wr_data), .base_we(base_we),
      .base_value(base_value), .branch(branch), .branch_target(branch_target),
      .psr_restore(psr_restore)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // models: memory and two register banks
   logic [31:0] mem   [256];
   logic [31:0] cbank [16];
   logic [31:0] ubank [16];
   logic        init_req = 1'b0;
   logic [7:0]  rpat = 8'hFF;
   logic [2:0]  pcnt = '0;
   logic        ready_q = 1'b0;

   assign mem_ready  = ready_q;
   assign mem_rdata  = mem[mem_addr[9:2]];
   assign rf_rd_data = rf_user ? ubank[rf_idx] : cbank[rf_idx];

   always @(posedge clk) begin
      pcnt    <= pcnt + 3'd1;
      ready_q <= rpat[pcnt];
      if (init_req) begin
         for (int i = 0; i < 256; i++) mem[i] <= 32'h5A00_0000 | i;
         for (int i = 0; i < 16; i++) begin
            cbank[i] <= 32'hC000_0000 | i;
            ubank[i] <= 32'hE000_0000 | i;
         end
      end else begin
         if (mem_valid && mem_ready && mem_write) mem[mem_addr[9:2]] <= mem_wdata;
         if (rf_we) begin
            if (rf_user) ubank[rf_idx] <= rf_wr_data;
            else         cbank[rf_idx] <= rf_wr_data;
         end
      end
   end

   // beat and completion monitor
   logic [31:0] exp_addr;
   logic [15:0] exp_mask;
   int          beats = 0;
   int          dones = 0;
   logic        d_bwe, d_br, d_psr;
   logic [31:0] d_bval, d_tgt;

   always @(negedge clk) begin
      if (rst_n && mem_valid && mem_ready) begin
         int lo;
         lo = 0;
         for (int i = 15; i >= 0; i--) if (exp_mask[i]) lo = i;
         // R3
         chk(mem_addr == exp_addr, "R3 beat address", mem_addr, exp_addr);
         chk(rf_idx == lo[3:0], "R3 beat register order", {28'd0, rf_idx}, lo);
         exp_addr = exp_addr + 32'd4;
         exp_mask[lo] = 1'b0;
         beats++;
      end
      if (rst_n && done) begin
         dones++;
         d_bwe  = base_we;
         d_bval = base_value;
         d_br   = branch;
         d_tgt  = branch_target;
         d_psr  = psr_restore;
      end
   end

   function automatic logic [31:0] first_of(input logic [31:0] b, input logic [1:0] m, input int n);
      case (m)
         2'd0: return b;
         2'd1: return b + 32'd4;
         2'd2: return b - 32'(4 * n) + 32'd4;
         default: return b - 32'(4 * n);
      endcase
   endfunction

   task automatic reinit();
      @(negedge clk); init_req = 1'b1;
      @(negedge clk); init_req = 1'b0;
   endtask

   task automatic launch(input logic [15:0] m, input logic [31:0] b, input logic [1:0] md,
                         input logic ld, input logic wb, input logic us);
      int n;
      n = $countones(m);
      exp_addr = first_of(b, md, n);
      exp_mask = m;
      beats = 0;
      dones = 0;
      d_bwe = 0; d_br = 0; d_psr = 0;
      @(negedge clk);
      reg_mask = m; base_addr = b; addr_mode = md;
      is_load = ld; wb_en = wb; user_bank = us; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      int t;
      t = 0;
      while (dones == 0 && t < 2000) begin
         @(posedge clk);
         t++;
      end
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic verify(input logic [15:0] m, input logic [31:0] b, input logic [1:0] md,
                         input logic ld, input logic wb, input logic us);
      int n;
      logic [31:0] a, fb;
      logic ub;
      n  = $countones(m);
      a  = first_of(b, md, n);
      fb = md[1] ? b - 32'(4 * n) : b + 32'(4 * n);
      ub = us && !m[15];
      chk(beats == n, "R4 beat count", beats, n);
      chk(dones == 1, "R6 single done", dones, 1);
      chk(busy == 1'b0, "R6 idle after done", {31'd0, busy}, 0);
      if (wb) chk(d_bwe && d_bval == fb, "R8 base update", d_bval, fb);
      else    chk(!d_bwe, "R8 no base update", {31'd0, d_bwe}, 0);
      for (int r = 0; r < 16; r++) begin
         if (m[r]) begin
            if (ld) begin
               logic [31:0] e;
               e = 32'h5A00_0000 | {24'd0, a[9:2]};
               if (ub) begin
                  chk(ubank[r] == e, "R11 user bank load", ubank[r], e);
                  chk(cbank[r] == (32'hC000_0000 | r), "R11 current bank untouched", cbank[r], 32'hC000_0000 | r);
               end else begin
                  chk(cbank[r] == e, "R5 load data", cbank[r], e);
                  chk(ubank[r] == (32'hE000_0000 | r), "R10 user bank untouched", ubank[r], 32'hE000_0000 | r);
               end
            end else begin
               logic [31:0] e;
               e = (ub ? 32'hE000_0000 : 32'hC000_0000) | r;
               chk(mem[a[9:2]] == e, "R5 store data", mem[a[9:2]], e);
            end
            a = a + 32'd4;
         end
      end
      if (ld && m[15]) begin
         logic [31:0] t;
         t = 32'h5A00_0000 | {24'd0, (a[9:2] - 8'd1)};
         chk(d_br && d_tgt == t, "R9 branch target", d_tgt, t);
         chk(d_psr == us, "R10 status restore", {31'd0, d_psr}, {31'd0, us});
      end else begin
         chk(!d_br && !d_psr, "R9 no branch", {30'd0, d_br, d_psr}, 0);
      end
   endtask

   typedef struct packed {
      logic [15:0] m;
      logic [31:0] b;
      logic [1:0]  md;
      logic        ld;
      logic        wb;
      logic        us;
      logic [7:0]  rp;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{16'h00F0, 32'h200, 2'd0, 1'b0, 1'b1, 1'b0, 8'hFF},
      '{16'h8421, 32'h200, 2'd1, 1'b1, 1'b1, 1'b0, 8'hA5},
      '{16'h0F0F, 32'h280, 2'd2, 1'b0, 1'b1, 1'b0, 8'h6D},
      '{16'h3001, 32'h240, 2'd3, 1'b1, 1'b0, 1'b0, 8'hFF},
      '{16'hFFFF, 32'h300, 2'd3, 1'b0, 1'b1, 1'b0, 8'h93},
      '{16'h0001, 32'h100, 2'd2, 1'b1, 1'b1, 1'b0, 8'h0F},
      '{16'h7FFE, 32'h180, 2'd1, 1'b1, 1'b0, 1'b1, 8'hFF},
      '{16'h8003, 32'h200, 2'd0, 1'b1, 1'b1, 1'b1, 8'hCC}
   };

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      reinit();
      repeat (3) @(negedge clk);
      // R1
      chk(!busy && !mem_valid && !rf_we && !done, "R1 reset idle", {28'd0, busy, mem_valid, rf_we, done}, 0);
      chk(!base_we && !branch && !psr_restore, "R1 reset strobes", {29'd0, base_we, branch, psr_restore}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 R4 R5 R8 R9 R10 R11: vector table
      for (int v = 0; v < 8; v++) begin
         reinit();
         rpat = VECS[v].rp;
         launch(VECS[v].m, VECS[v].b, VECS[v].md, VECS[v].ld, VECS[v].wb, VECS[v].us);
         wait_done();
         verify(VECS[v].m, VECS[v].b, VECS[v].md, VECS[v].ld, VECS[v].wb, VECS[v].us);
      end

      // R7: empty mask completes at once with no beat
      reinit();
      rpat = 8'hFF;
      launch(16'h0000, 32'h200, 2'd3, 1'b1, 1'b1, 1'b0);
      chk(done == 1'b1, "R7 done next cycle", {31'd0, done}, 1);
      chk(!mem_valid, "R7 no memory request", {31'd0, mem_valid}, 0);
      @(negedge clk);
      chk(!done && !busy, "R7 back to idle", {30'd0, done, busy}, 0);
      chk(beats == 0, "R7 no beats", beats, 0);

      // R6 busy window, R12 start ignored while busy
      reinit();
      rpat = 8'h11;
      launch(16'h00C3, 32'h200, 2'd0, 1'b0, 1'b1, 1'b0);
      chk(busy == 1'b1, "R6 busy after start", {31'd0, busy}, 1);
      @(negedge clk);
      reg_mask = 16'hFFFF; base_addr = 32'h300; addr_mode = 2'd3; is_load = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      verify(16'h00C3, 32'h200, 2'd0, 1'b0, 1'b1, 1'b0);
      repeat (4) @(negedge clk);
      chk(!busy && beats == 4, "R12 second start ignored", beats, 4);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule